// File: doc/BRIEF.md
# TDO Scan Serializer with Pseudo-Random Pattern Mode

This block drives the serial test-data output of a scan master. In its normal mode it holds up to two bytes written in parallel and sends them out one bit per scan-clock falling edge, least significant bit first. While one byte is being shifted out, the other slot can take the next byte. An external bit counter marks the eighth bit of a byte. An external scan-length counter can end a byte early at its terminal count. In either case the active slot is released and the other slot becomes the active one. Any bits of a byte that is ended early are discarded.

When the pattern mode bit is set, the serial output is taken from a 32-bit linear feedback shift register instead. Its feedback polynomial is x^32+x^22+x^2+x+1. Four byte writes load the register, lowest byte first. The register then advances once on every enabled scan-clock falling edge.

The block runs on the system clock. Each scan-clock falling edge reaches the block as a one-cycle strobe. A pad driver uses the separate drive-enable output to put the serial output pin into high impedance.

Top module: `tdo_serializer`

## Requirements
- R1: While `rst_n` is low at a clock edge, `tdo` is 1 after that edge, `buf_empty` is 1 and `buf_full` is 0.
- R2: A byte write in normal mode is accepted whenever fewer than two bytes are held, whatever the value of `scan_en`. A write that arrives while two bytes are held is dropped. `buf_full` is 1 when two bytes are held and `buf_empty` is 1 when none are held.
- R3: A normal-mode shift happens only when `scan_en`, `tck_ok` and `sck_fall` are all 1, `loopback` is 0 and at least one byte is held. In any other cycle `tdo` keeps its value.
- R4: Each shift puts the next bit of the active byte on `tdo` one clock after the strobe, starting with bit 0.
- R5: A shift with `byte_done` = 1 ends the active byte. The next shift then takes bit 0 of the byte that was written next.
- R6: A shift with `term_cnt` = 1 also ends the active byte, and its unshifted bits are discarded.
- R7: While `loopback` is 1, `tdo` holds and no bit is consumed, in either mode.
- R8: `tdo_oe` is 1 exactly when `oe_n` is 0, so the pin is high impedance while `oe_n` is 1.
- R9: With `prpg_mode` = 1, four writes load the 32-bit register, the first byte into bits 7:0. Each enabled strobe then moves bit 0 of the register onto `tdo` and shifts the register right by one. The new bit 31 is the XOR of bits 0, 1, 2 and 22, so the output bits follow a(n+32) = a(n+22) ^ a(n+2) ^ a(n+1) ^ a(n).
- R10: If the loaded seed is all zeros, the value 32'h0000_0001 is loaded instead. The register never holds zero.
- R11: In pattern mode the register advances only when `scan_en`, `tck_ok` and `sck_fall` are 1 and `loopback` is 0. Otherwise `tdo` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to write (buffer byte or seed byte) |
| buf_full | output | 1 | Both byte slots hold data |
| buf_empty | output | 1 | No byte slot holds data |
| scan_en | input | 1 | Mode bit enabling serial output shifting |
| prpg_mode | input | 1 | Mode bit selecting pattern generator operation |
| sck_fall | input | 1 | One-cycle strobe marking a scan-clock falling edge |
| tck_ok | input | 1 | Test-clock enable qualifier from clock control |
| byte_done | input | 1 | This shift is the eighth bit of the byte |
| term_cnt | input | 1 | Scan-length counter at terminal count |
| loopback | input | 1 | Loop-back test in progress, output frozen |
| oe_n | input | 1 | Active-low output enable for the pad |
| tdo | output | 1 | Serial test data output value |
| tdo_oe | output | 1 | Pad drive enable, low means high impedance |

## Verification
The output register sits one clock behind the inputs. A bit selected by a strobe in one cycle therefore appears on `tdo` after the next rising edge. `buf_full` and `buf_empty` change after that same edge. `tdo_oe` follows `oe_n` with no delay. The bench drives every input 5 ns after a rising edge and samples every output 5 ns after the following rising edge. Each result is compared in the cycle in which it first becomes valid. The bench models the buffer and the register in its own terms: a two-entry byte queue with a bit pointer, and the output-bit recurrence of the polynomial. It checks every cycle of a random run, including cycles with no strobe, where the held value is what it expects.

// File: rtl/tdo_ser_pkg.sv
// Shared parameters for the TDO serializer.
// Assumes byte-wide writes and a register width that is a whole number of bytes.
package tdo_ser_pkg;
    localparam int BYTE_W    = 8;
    localparam int PRPG_W    = 32;
    // Feedback taps of x^32+x^22+x^2+x+1 for a right-shifting register
    localparam logic [PRPG_W-1:0] PRPG_TAPS    = 32'h0040_0007;
    localparam logic [PRPG_W-1:0] PRPG_DEFAULT = 32'h0000_0001;
endpackage

// File: rtl/tdo_byte_pingpong.sv
// Two-slot byte buffer that serializes bytes LSB first.
// Assumes the caller gates `shift` with its own qualifiers.
// `last` releases the active slot and drops its remaining bits.
module tdo_byte_pingpong #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              shift,
    input  logic              last,
    output logic              bit_out,
    output logic              full,
    output logic              empty
);
    localparam int SLOTS = 2;

    logic [DATA_W-1:0] slot_q [SLOTS];
    logic [SLOTS-1:0]  valid_q;
    logic              rd_sel_q;
    logic              wr_sel_q;
    logic              wr_ok;
    logic              sh_ok;

    assign full    = &valid_q;
    assign empty   = ~|valid_q;
    assign wr_ok   = wr_en & ~full;
    assign sh_ok   = shift & ~empty;
    assign bit_out = slot_q[rd_sel_q][0];

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_slot
            // Load a slot on a write, shift it while it is active, and release it on its last bit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    slot_q[g]  <= '0;
                    valid_q[g] <= 1'b0;
                end else begin
                    if (sh_ok && rd_sel_q == 1'(g)) begin
                        slot_q[g] <= slot_q[g] >> 1;
                        if (last) valid_q[g] <= 1'b0;
                    end
                    if (wr_ok && wr_sel_q == 1'(g)) begin
                        slot_q[g]  <= wr_data;
                        valid_q[g] <= 1'b1;
                    end
                end
            end
        end
    endgenerate

    // Move the read and write pointers between the two slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_sel_q <= 1'b0;
            wr_sel_q <= 1'b0;
        end else begin
            if (sh_ok && last) rd_sel_q <= ~rd_sel_q;
            if (wr_ok)         wr_sel_q <= ~wr_sel_q;
        end
    end

    p_full_drops_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !(shift && last)) |=> full);

    p_last_releases_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(valid_q) == 1 && shift && last && !wr_en) |=> empty);

    p_empty_stays_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> empty);
endmodule

// File: rtl/tdo_prpg_lfsr.sv
// 32-bit pattern generator with a seed that is loaded a byte at a time.
// Bytes are staged until the last one arrives, so the state is never zero.
// An all-zero seed is replaced by the default value.
module tdo_prpg_lfsr
    import tdo_ser_pkg::*;
#(
    parameter int              DATA_W  = BYTE_W,
    parameter int              LFSR_W  = PRPG_W,
    parameter logic [LFSR_W-1:0] TAPS  = PRPG_TAPS,
    parameter logic [LFSR_W-1:0] SEED0 = PRPG_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_on,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              step,
    output logic              bit_out
);
    localparam int NBYTES = LFSR_W / DATA_W;
    localparam int IDX_W  = $clog2(NBYTES);
    localparam int STG_W  = LFSR_W - DATA_W;

    logic [LFSR_W-1:0] state_q;
    logic [STG_W-1:0]  stage_q;
    logic [IDX_W-1:0]  idx_q;
    logic [LFSR_W-1:0] seed_full;
    logic              load_full;
    logic              feedback;

    assign seed_full = {wr_data, stage_q};
    assign load_full = mode_on && wr_en && (idx_q == IDX_W'(NBYTES - 1));
    assign feedback  = ^(state_q & TAPS);
    assign bit_out   = state_q[0];

    // Stage the seed bytes in order
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
            idx_q   <= '0;
        end else if (!mode_on) begin
            idx_q <= '0;
        end else if (wr_en) begin
            if (load_full) begin
                idx_q <= '0;
            end else begin
                stage_q[int'(idx_q)*DATA_W +: DATA_W] <= wr_data;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Load the full seed, or step the register right with feedback into the top bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED0;
        end else if (load_full) begin
            state_q <= (seed_full == '0) ? SEED0 : seed_full;
        end else if (step) begin
            state_q <= {feedback, state_q[LFSR_W-1:1]};
        end
    end

    p_never_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    p_step_shifts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load_full) |=> state_q[LFSR_W-2:0] == $past(state_q[LFSR_W-1:1]));
endmodule

// File: rtl/tdo_serializer.sv
// Top of the TDO scan serializer.
// Qualifies the scan-clock strobe and picks the buffer or the pattern generator.
// Registers the output bit. Assumes that sck_fall is a one-cycle pulse per falling edge.
module tdo_serializer
    import tdo_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              buf_full,
    output logic              buf_empty,
    input  logic              scan_en,
    input  logic              prpg_mode,
    input  logic              sck_fall,
    input  logic              tck_ok,
    input  logic              byte_done,
    input  logic              term_cnt,
    input  logic              loopback,
    input  logic              oe_n,
    output logic              tdo,
    output logic              tdo_oe
);
    logic shift_go;
    logic pp_shift;
    logic pp_bit;
    logic lfsr_step;
    logic lfsr_bit;
    logic tdo_q;

    assign shift_go  = scan_en & tck_ok & sck_fall & ~loopback;
    assign pp_shift  = shift_go & ~prpg_mode;
    assign lfsr_step = shift_go & prpg_mode;

    tdo_byte_pingpong #(.DATA_W(BYTE_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en & ~prpg_mode),
        .wr_data (wr_data),
        .shift   (pp_shift),
        .last    (byte_done | term_cnt),
        .bit_out (pp_bit),
        .full    (buf_full),
        .empty   (buf_empty)
    );

    tdo_prpg_lfsr #(.DATA_W(BYTE_W), .LFSR_W(PRPG_W)) u_prpg (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_on (prpg_mode),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .step    (lfsr_step),
        .bit_out (lfsr_bit)
    );

    // Output register: high in reset, loads the bit that is shifted out, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n)                     tdo_q <= 1'b1;
        else if (pp_shift && !buf_empty) tdo_q <= pp_bit;
        else if (lfsr_step)             tdo_q <= lfsr_bit;
    end

    assign tdo    = tdo_q;
    assign tdo_oe = ~oe_n;

    p_reset_high_r1: assert property (@(posedge clk)
        !rst_n |=> tdo_q);

    p_loopback_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        loopback |=> $stable(tdo_q));

    p_no_strobe_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(tdo_q));

    p_oe_pad_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tdo_oe != oe_n);
endmodule

// File: tb/tdo_serializer_tb_top.sv
module tdo_serializer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       scan_en = 1'b0, prpg_mode = 1'b0, sck_fall = 1'b0, tck_ok = 1'b0;
    logic       byte_done = 1'b0, term_cnt = 1'b0, loopback = 1'b0, oe_n = 1'b0;
    logic       buf_full, buf_empty, tdo, tdo_oe;

    int checks = 0;
    int fails  = 0;
    logic refbits [0:511];

    always #10 clk = ~clk;

    tdo_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .buf_full(buf_full), .buf_empty(buf_empty), .scan_en(scan_en),
        .prpg_mode(prpg_mode), .sck_fall(sck_fall), .tck_ok(tck_ok),
        .byte_done(byte_done), .term_cnt(term_cnt), .loopback(loopback),
        .oe_n(oe_n), .tdo(tdo), .tdo_oe(tdo_oe)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance to 5 ns after the next rising edge
    task automatic tick;
        @(posedge clk);
        #5;
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic shift_one(input logic done, input logic tc);
        scan_en = 1'b1; tck_ok = 1'b1; sck_fall = 1'b1; byte_done = done; term_cnt = tc;
        tick();
        sck_fall = 1'b0; byte_done = 1'b0; term_cnt = 1'b0;
    endtask

    // Output bits of x^32+x^22+x^2+x+1 from a seed, as a recurrence
    function automatic void build_ref(input logic [31:0] seed);
        for (int i = 0; i < 512; i++)
            refbits[i] = (i < 32) ? seed[i]
                       : refbits[i-32] ^ refbits[i-31] ^ refbits[i-30] ^ refbits[i-10];
    endfunction

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  qb [2];
        int          cnt, head, tail, bitpos;
        logic        exp_tdo;
        logic [31:0] seed;
        int          k;

        void'($urandom(32'd2024));
        // R1 reset state
        tick(); tick();
        chk("R1 tdo", tdo, 1);
        chk("R1 empty", buf_empty, 1);
        chk("R1 full", buf_full, 0);
        oe_n = 1'b1; #1;
        chk("R8 oe_n high", tdo_oe, 0);
        oe_n = 1'b0; #1;
        chk("R8 oe_n low", tdo_oe, 1);
        rst_n = 1'b1;
        tick();

        // R2 writes with scan_en low, then overflow
        write_byte(8'hA5);
        chk("R2 one byte", {buf_full, buf_empty}, 2'b00);
        write_byte(8'h3C);
        chk("R2 full", buf_full, 1);
        write_byte(8'hFF);
        chk("R2 still full", buf_full, 1);
        // R3 qualifier missing: no shift
        scan_en = 1'b0; tck_ok = 1'b1; sck_fall = 1'b1; tick(); sck_fall = 1'b0;
        chk("R3 scan_en low hold", tdo, 1);
        scan_en = 1'b1; tck_ok = 1'b0; sck_fall = 1'b1; tick(); sck_fall = 1'b0;
        chk("R3 tck_ok low hold", tdo, 1);
        chk("R3 nothing consumed", buf_full, 1);
        // R4/R5 LSB first, byte order kept, dropped write never seen
        for (int b = 0; b < 8; b++) begin
            shift_one(b == 7, 1'b0);
            chk("R4 bit of A5", tdo, (8'hA5 >> b) & 1);
        end
        chk("R5 slot released", {buf_full, buf_empty}, 2'b00);
        for (int b = 0; b < 8; b++) begin
            shift_one(b == 7, 1'b0);
            chk("R5 bit of 3C", tdo, (8'h3C >> b) & 1);
        end
        chk("R2 overflow byte dropped", buf_empty, 1);
        shift_one(1'b0, 1'b0);
        chk("R3 empty hold", tdo, 0);

        // R6 truncation, R7 loopback
        write_byte(8'hF0);
        write_byte(8'h0D);
        shift_one(1'b0, 1'b0); shift_one(1'b0, 1'b0);
        shift_one(1'b0, 1'b1);
        chk("R6 truncated bit", tdo, 0);
        chk("R6 slot released", buf_full, 0);
        shift_one(1'b0, 1'b0);
        chk("R6 next byte bit0", tdo, 1);
        loopback = 1'b1; shift_one(1'b0, 1'b0); loopback = 1'b0;
        chk("R7 loopback hold", tdo, 1);
        shift_one(1'b0, 1'b0);
        chk("R7 bit not consumed", tdo, 0);
        shift_one(1'b0, 1'b1);
        chk("R6 drain", buf_empty, 1);

        // Random normal-mode run against a two-entry queue model
        cnt = 0; head = 0; tail = 0; bitpos = 0; exp_tdo = tdo;
        for (int c = 0; c < 3000; c++) begin
            logic w, f, e, t, tc, lb, go, dn;
            logic [7:0] d;
            w  = ($urandom % 2) == 0;
            d  = 8'($urandom);
            f  = ($urandom % 3) != 0;
            e  = ($urandom % 8) != 0;
            t  = ($urandom % 8) != 0;
            tc = ($urandom % 16) == 0;
            lb = ($urandom % 20) == 0;
            dn = (bitpos == 7);
            wr_en = w; wr_data = d; sck_fall = f; scan_en = e; tck_ok = t;
            term_cnt = tc; byte_done = dn; loopback = lb;
            go = e && t && f && !lb && (cnt > 0);
            tick();
            if (go) begin
                exp_tdo = qb[head][bitpos];
                bitpos++;
                if (dn || tc) begin
                    head = 1 - head; cnt--; bitpos = 0;
                end
            end
            if (w && (cnt + (go && (bitpos == 0) ? 1 : 0)) < 2) begin
                qb[tail] = d; tail = 1 - tail; cnt++;
            end
            chk("R3 R4 R5 R6 random tdo", tdo, exp_tdo);
            chk("R2 random full", buf_full, cnt == 2);
            chk("R2 random empty", buf_empty, cnt == 0);
        end
        wr_en = 1'b0; sck_fall = 1'b0; term_cnt = 1'b0; byte_done = 1'b0; loopback = 1'b0;
        tick();

        // R9 R11 pattern mode with a random seed and random stalls
        prpg_mode = 1'b1; tick();
        seed = $urandom;
        for (int i = 0; i < 4; i++) write_byte(seed[i*8 +: 8]);
        build_ref(seed);
        k = 0;
        exp_tdo = tdo;
        while (k < 400) begin
            logic f, t, lb;
            f  = ($urandom % 4) != 0;
            t  = ($urandom % 6) != 0;
            lb = ($urandom % 12) == 0;
            scan_en = 1'b1; sck_fall = f; tck_ok = t; loopback = lb;
            tick();
            if (f && t && !lb) begin
                exp_tdo = refbits[k];
                k++;
            end
            chk("R9 R11 pattern bit", tdo, exp_tdo);
        end
        sck_fall = 1'b0; loopback = 1'b0;

        // R10 all-zero seed falls back to 1
        prpg_mode = 1'b0; tick();
        prpg_mode = 1'b1; tick();
        for (int i = 0; i < 4; i++) write_byte(8'h00);
        build_ref(32'h0000_0001);
        for (int i = 0; i < 64; i++) begin
            shift_one(1'b0, 1'b0);
            chk("R10 default seed bit", tdo, refbits[i]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule